// File: doc/BRIEF.md
# Bouncing Square Pattern Generator

This block generates the colour of each pixel for a 640x480 raster. A separate timing generator supplies the current pixel coordinates. The block draws a solid square over a flat background. The square travels diagonally across the visible area and bounces back from each edge. The background colour changes by itself in response to a slow colour tick. Every colour uses a packed 8-bit format: three red bits, then three green bits, then two blue bits.

Two slow enables set the pace of the pattern. Both are single-cycle pulses in the pixel clock domain. A motion tick of about 50 Hz moves the square, and a colour tick every 3 seconds changes the background. Two user settings shape the square: a 2-bit speed value and a size select. The output colour is registered once and leaves the block one pixel clock after its coordinates arrive.

Top module: `bounce_square_gen`

## Requirements
- R1: While reset is low, `pix_rgb` is 8'h00. On release, the square sits at (0,0) moving right and down, and the palette index is 0.
- R2: Colours are packed as bits [7:5] red, [4:2] green and [1:0] blue. Palette index i gives a background with red 3'b111 when i[0]=1, green 3'b111 when i[1]=1 and blue 2'b11 when i[2]=1. Each field is zero otherwise. Index 0 is therefore 8'h00 and index 7 is 8'hFF.
- R3: The square's position changes only on a cycle with `move_tick` high.
- R4: On each motion tick, the square moves `speed`+1 pixels on each axis, in that axis's current direction.
- R5: The square's edge length is 60 pixels when `size_big` is 0 and 80 pixels when it is 1. The value of `size_big` in the current cycle is used both for drawing and for the edge limits.
- R6: If a step would reach or pass the right limit (640 minus the edge length), the position is clamped to that limit and the direction becomes leftward. The bottom limit (480 minus the edge length) works the same way. If a leftward or upward step would reach or pass 0, the position is clamped to 0 and the direction is reversed.
- R7: If the square lies beyond a limit because the size grew, the next motion tick pulls it back to that limit.
- R8: The palette index is 3 bits wide. It advances by one, modulo 8, on each cycle with `color_tick` high, and holds otherwise.
- R9: A visible pixel inside the square shows the bitwise complement of the background colour. A visible pixel outside the square shows the background colour.
- R10: The colour for a coordinate pair appears one clock after that pair is presented. A pair with x >= 640 or y >= 480 gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| move_tick | input | 1 | Single-cycle motion enable, about 50 Hz |
| color_tick | input | 1 | Single-cycle background-step enable, every 3 s |
| speed | input | 2 | Speed setting; step is speed+1 pixels |
| size_big | input | 1 | 0 selects a 60-pixel square, 1 selects 80 pixels |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel line |
| pix_rgb | output | 8 | Registered pixel colour, RRRGGGBB |

## Verification
Three events can land in a single edge: a motion tick, a colour tick and a pixel draw. At that edge, the pixel must still use the old position and the old background. The new position and the new palette index apply only from the following cycle. The bench makes these collide by running the two ticks on co-prime periods, so that both ticks regularly fire in the same cycle. Pixel coordinates are kept close to the square's border on purpose. A behavioural model then judges every cycle's output against the state that existed before the edge.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int unsigned COORD_W = 10;
  localparam int unsigned SPEED_W = 2;
  localparam int unsigned PAL_W   = 3;
  localparam int unsigned RGB_W   = 8;
  localparam int unsigned WIDE_W  = COORD_W + 2;
  localparam int          MAX_STEP = 1 << SPEED_W;

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [SPEED_W-1:0] speed_t;
  typedef logic [PAL_W-1:0]   pal_t;
  typedef logic [RGB_W-1:0]   rgb_t;

  typedef struct packed {
    coord_t pos;
    logic   back;
  } axis_t;

  // pixels travelled per motion tick
  function automatic coord_t step_len(speed_t s);
    return coord_t'(s) + coord_t'(1);
  endfunction

  // one axis advance with clamp and reversal at both ends
  function automatic axis_t axis_step(coord_t pos, logic back, speed_t s, coord_t lim);
    logic signed [WIDE_W-1:0] cand;
    logic signed [WIDE_W-1:0] wlim;
    axis_t r;
    wlim = $signed({2'b00, lim});
    if (back) cand = $signed({2'b00, pos}) - $signed({2'b00, step_len(s)});
    else      cand = $signed({2'b00, pos}) + $signed({2'b00, step_len(s)});
    if (cand >= wlim) begin
      r.pos  = lim;
      r.back = 1'b1;
    end else if (cand[WIDE_W-1] || (cand == '0)) begin
      r.pos  = '0;
      r.back = 1'b0;
    end else begin
      r.pos  = coord_t'(cand);
      r.back = back;
    end
    return r;
  endfunction

  // bit 0 lights red, bit 1 green, bit 2 blue
  function automatic rgb_t palette(pal_t i);
    return {{3{i[0]}}, {3{i[1]}}, {2{i[2]}}};
  endfunction

  function automatic logic span_hit(coord_t p, coord_t base, coord_t len);
    return ({1'b0, p} >= {1'b0, base}) && ({1'b0, p} < ({1'b0, base} + {1'b0, len}));
  endfunction
endpackage

// File: rtl/bsq_axis.sv
module bsq_axis
  import bsq_pkg::*;
#(
  parameter int unsigned EXTENT = 640,
  parameter int unsigned SMALL  = 60,
  parameter int unsigned LARGE  = 80
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   move_tick,
  input  speed_t speed,
  input  logic   size_big,
  output coord_t pos
);
  localparam coord_t LIM_S = coord_t'(EXTENT - SMALL);
  localparam coord_t LIM_L = coord_t'(EXTENT - LARGE);

  logic   back;
  coord_t lim;
  axis_t  nxt;

  assign lim = size_big ? LIM_L : LIM_S;
  assign nxt = axis_step(pos, back, speed, lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      back <= 1'b0;
    end else if (move_tick) begin
      pos  <= nxt.pos;
      back <= nxt.back;
    end
  end

  // R3
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !move_tick |=> $stable(pos) && $stable(back));

  // R6
  lim_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_tick && !size_big |=> pos <= LIM_S);

  // R7
  lim_large_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_tick && size_big |=> pos <= LIM_L);

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_tick && (pos <= lim) |=>
      ((int'(pos) - int'($past(pos))) <= MAX_STEP) &&
      ((int'($past(pos)) - int'(pos)) <= MAX_STEP));
endmodule

// File: rtl/bsq_palette.sv
module bsq_palette
  import bsq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic color_tick,
  output rgb_t bg
);
  pal_t idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= '0;
    else if (color_tick) idx <= idx + pal_t'(1);
  end

  assign bg = palette(idx);

  // R8
  pal_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    color_tick |=> idx == $past(idx) + pal_t'(1));

  // R8
  pal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !color_tick |=> $stable(idx));
endmodule

// File: rtl/bsq_pixel.sv
module bsq_pixel
  import bsq_pkg::*;
#(
  parameter int unsigned H_VIS = 640,
  parameter int unsigned V_VIS = 480,
  parameter int unsigned SMALL = 60,
  parameter int unsigned LARGE = 80
) (
  input  logic   clk,
  input  logic   rst_n,
  input  coord_t pix_x,
  input  coord_t pix_y,
  input  coord_t sq_x,
  input  coord_t sq_y,
  input  logic   size_big,
  input  rgb_t   bg,
  output rgb_t   rgb
);
  coord_t edge_len;
  logic   on_screen;
  logic   in_sq;

  assign edge_len  = size_big ? coord_t'(LARGE) : coord_t'(SMALL);
  assign on_screen = (pix_x < coord_t'(H_VIS)) && (pix_y < coord_t'(V_VIS));
  assign in_sq     = span_hit(pix_x, sq_x, edge_len) && span_hit(pix_y, sq_y, edge_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rgb <= '0;
    else if (!on_screen) rgb <= '0;
    else if (in_sq)     rgb <= ~bg;
    else                rgb <= bg;
  end

  // R10
  offscreen_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on_screen |=> rgb == '0);

  // R9
  square_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_screen && in_sq |=> rgb == ~$past(bg));

  // R9
  backdrop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_screen && !in_sq |=> rgb == $past(bg));
endmodule

// File: rtl/bounce_square_gen.sv
module bounce_square_gen
  import bsq_pkg::*;
#(
  parameter int unsigned H_VIS      = 640,
  parameter int unsigned V_VIS      = 480,
  parameter int unsigned EDGE_SMALL = 60,
  parameter int unsigned EDGE_LARGE = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               move_tick,
  input  logic               color_tick,
  input  logic [SPEED_W-1:0] speed,
  input  logic               size_big,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  output logic [RGB_W-1:0]   pix_rgb
);
  coord_t sq_x, sq_y;
  rgb_t   bg_rgb;

  bsq_axis #(.EXTENT(H_VIS), .SMALL(EDGE_SMALL), .LARGE(EDGE_LARGE)) u_ax_x (
    .clk(clk), .rst_n(rst_n), .move_tick(move_tick), .speed(speed),
    .size_big(size_big), .pos(sq_x)
  );

  bsq_axis #(.EXTENT(V_VIS), .SMALL(EDGE_SMALL), .LARGE(EDGE_LARGE)) u_ax_y (
    .clk(clk), .rst_n(rst_n), .move_tick(move_tick), .speed(speed),
    .size_big(size_big), .pos(sq_y)
  );

  bsq_palette u_pal (
    .clk(clk), .rst_n(rst_n), .color_tick(color_tick), .bg(bg_rgb)
  );

  bsq_pixel #(.H_VIS(H_VIS), .V_VIS(V_VIS), .SMALL(EDGE_SMALL), .LARGE(EDGE_LARGE)) u_pix (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .sq_x(sq_x), .sq_y(sq_y), .size_big(size_big), .bg(bg_rgb), .rgb(pix_rgb)
  );

  // R1
  reset_origin_chk: assert property (@(posedge clk)
    !rst_n |=> (sq_x == '0) && (sq_y == '0) && (bg_rgb == '0));
endmodule

// File: tb/sim_bounce_square_gen.sv
module sim_bounce_square_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       move_tick = 1'b0;
  logic       color_tick = 1'b0;
  logic [1:0] speed = 2'd0;
  logic       size_big = 1'b0;
  logic [9:0] pix_x = 10'd0;
  logic [9:0] pix_y = 10'd0;
  wire  [7:0] pix_rgb;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";
  int    mx = 0, my = 0, mdx = 1, mdy = 1, midx = 0;

  bounce_square_gen u0 (
    .clk(clk), .rst_n(rst_n), .move_tick(move_tick), .color_tick(color_tick),
    .speed(speed), .size_big(size_big), .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb)
  );

  always #2 clk = ~clk;

  // R2: background colour by palette index
  function automatic int pal(int i);
    int c = 0;
    if (i % 2 == 1)       c += 224;
    if ((i / 2) % 2 == 1) c += 28;
    if ((i / 4) % 2 == 1) c += 3;
    return c;
  endfunction

  // R6/R7: one axis of the reference motion
  task automatic bounce(inout int p, inout int d, input int stp, input int lim);
    int t = p + d * stp;
    if (t >= lim) begin p = lim; d = -1; end
    else if (t <= 0) begin p = 0; d = 1; end
    else p = t;
  endtask

  task automatic judge();
    int sz = size_big ? 80 : 60;
    int x = int'(pix_x);
    int y = int'(pix_y);
    int e;
    string tag;
    bit on, ins;
    if (!rst_n) begin
      e = 0; tag = "R1";
      mx = 0; my = 0; mdx = 1; mdy = 1; midx = 0;
    end else begin
      on  = (x < 640) && (y < 480);
      ins = (x >= mx) && (x < mx + sz) && (y >= my) && (y < my + sz);
      if (!on)      begin e = 0;                  tag = "R10"; end
      else if (ins) begin e = 255 - pal(midx);    tag = "R9";  end
      else          begin e = pal(midx);          tag = "R8";  end
    end
    checks++;
    if (pix_rgb !== 8'(e)) begin
      fails++;
      $display("FAIL %s [%s] x=%0d y=%0d sq=(%0d,%0d) got %02h expected %02h",
               tag, phase, x, y, mx, my, pix_rgb, 8'(e));
    end
    if (rst_n) begin
      if (move_tick) begin
        bounce(mx, mdx, int'(speed) + 1, 640 - sz);
        bounce(my, mdy, int'(speed) + 1, 480 - sz);
      end
      if (color_tick) midx = (midx + 1) % 8;
    end
  endtask

  // mode 0: near the square, 1: anywhere, 2: off the visible area
  task automatic drive(int mode, bit mt, bit ct);
    int sz = size_big ? 80 : 60;
    int x, y;
    if (mode == 0) begin
      x = mx - 4 + int'($urandom_range(0, sz + 8));
      y = my - 4 + int'($urandom_range(0, sz + 8));
    end else if (mode == 1) begin
      x = int'($urandom_range(0, 1023));
      y = int'($urandom_range(0, 1023));
    end else if ($urandom_range(0, 1) == 1) begin
      x = int'($urandom_range(640, 1023));
      y = int'($urandom_range(0, 1023));
    end else begin
      x = int'($urandom_range(0, 1023));
      y = int'($urandom_range(480, 1023));
    end
    if (x < 0) x = 0;
    if (y < 0) y = 0;
    if (x > 1023) x = 1023;
    if (y > 1023) y = 1023;
    pix_x = 10'(x);
    pix_y = 10'(y);
    move_tick = mt;
    color_tick = ct;
    @(posedge clk);
    #1;
    judge();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    // R1: output held at zero under reset
    phase = "R1";
    for (int i = 0; i < 5; i++) drive(1, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) drive(0, 1'b0, 1'b0);

    // R3: sparse motion ticks, no movement between them
    phase = "R3";
    for (int i = 0; i < 200; i++) drive((i % 3 == 0) ? 1 : 0, (i % 25) == 24, 1'b0);

    // R4: every speed setting
    phase = "R4";
    for (int s = 1; s < 4; s++) begin
      speed = 2'(s);
      for (int i = 0; i < 300; i++) drive(0, (i % 10) == 9, 1'b0);
    end

    // R5: size toggled while drawing
    phase = "R5";
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) size_big = ~size_big;
      drive(0, (i % 6) == 5, 1'b0);
    end

    // R6: fast motion, many bounces on both axes
    phase = "R6";
    size_big = 1'b0;
    speed = 2'd3;
    for (int i = 0; i < 4000; i++) drive((i % 4 == 0) ? 1 : 0, (i % 2) == 1, 1'b0);

    // R7: grow the square while it sits near the right limit
    phase = "R7";
    for (int i = 0; i < 1000 && mx < 566; i++) drive(0, 1'b1, 1'b0);
    size_big = 1'b1;
    for (int i = 0; i < 300; i++) drive(0, (i % 3) == 0, 1'b0);

    // R2/R8: colour ticks, colliding with motion ticks every 35 cycles
    phase = "R2/R8";
    speed = 2'd1;
    for (int i = 0; i < 800; i++) drive((i % 4 == 0) ? 1 : 0, (i % 5) == 0, (i % 7) == 0);

    // R10: coordinates beyond the visible area
    phase = "R10";
    for (int i = 0; i < 300; i++) drive(2, (i % 9) == 0, (i % 11) == 0);

    summary();
    $finish;
  end
endmodule